// File: doc/BRIEF.md
# Dual-Mode Core Watchdog Timer

This block is a down-counting timer placed beside one processor core. It runs in one of two modes. As a general-purpose timer it sets an interrupt flag on each expiry and drives an interrupt line when that interrupt is enabled. As a watchdog it sets a reset flag on expiry and holds a reset request until software clears that flag. Software controls it through a small word-addressed register bus. The registers are load, counter, control, interrupt flag, reset flag and an unlock register.

Entering watchdog mode takes one control write. Leaving it needs two key values written in sequence to the unlock register, so runaway code cannot quietly switch the watchdog off. An 8-bit prescaler stretches each count step, and the counter either reloads and keeps running or stops after a single expiry.

Top module: `core_wdog_timer`

## Requirements
- R1: After reset the block is in timer mode. The control, load, counter and both flags read 0, and `irq` and `rstReq` are low.
- R2: Register index (`busAddr`): 0 load, 1 counter (read-only), 2 control, 3 interrupt flag, 4 reset flag, 5 unlock. Control bits: bit 0 enable, bit 1 auto-reload, bit 2 interrupt enable, bit 3 watchdog mode, bits 15:8 prescaler. With the counter loaded with L and prescaler P, expiry comes (L+1)×(P+1) clocks after the enable write.
- R3: With auto-reload set, expiry reloads the counter from the load register and counting continues, so the next expiry follows one full period later.
- R4: With auto-reload clear, expiry leaves the counter at 0 and clears the enable bit.
- R5: A write to the load register stores the low CNT_W bits and puts that value into the counter on the next clock edge. This holds while counting, and it restarts the prescaler.
- R6: While the enable bit is 0, the counter value does not change except through a load write.
- R7: A control write with bit 3 set enters watchdog mode at once. A control write with bit 3 clear leaves the mode unchanged.
- R8: Watchdog mode is left only when 0x12345678 and then 0x87654321 are written to the unlock register, with no other bus access (`busSel` high) between them. Any other access, or a wrong key, restarts the sequence.
- R9: Writing 1 to bit 0 of a flag register clears that flag. Writing 0 leaves it set.
- R10: In watchdog mode, expiry sets the reset flag and not the interrupt flag. `rstReq` stays high until the reset flag is cleared.
- R11: `irq` is high only when the interrupt flag and interrupt enable are both set and the block is in timer mode. Interrupt enable has no effect in watchdog mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access strobe, one access per cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Register index |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| irq | output | 1 | Timer-mode interrupt |
| rstReq | output | 1 | Watchdog reset request |

## Verification
The bench builds the block with a 16-bit counter and the full 8-bit prescaler. This keeps periods short enough to run many expiries, in both modes and with both reload behaviours. Small loads and prescalers of 0 and 1 exercise the exact period formula and expiry on the first step. The narrow counter also means the low-bit truncation of load writes is exercised, because writes carry data in the upper bits.

// File: rtl/core_wdog_pkg.sv
package core_wdog_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  typedef enum logic [ADDR_W-1:0] {
    REG_LOAD  = 3'd0,
    REG_COUNT = 3'd1,
    REG_CTRL  = 3'd2,
    REG_IFLAG = 3'd3,
    REG_RFLAG = 3'd4,
    REG_UNLK  = 3'd5
  } regIdx_e;

  localparam int BIT_EN  = 0;
  localparam int BIT_AR  = 1;
  localparam int BIT_IE  = 2;
  localparam int BIT_WD  = 3;
  localparam int PRE_LSB = 8;

  localparam logic [DATA_W-1:0] KEY_FIRST  = 32'h1234_5678;
  localparam logic [DATA_W-1:0] KEY_SECOND = 32'h8765_4321;

  typedef enum logic {UNL_IDLE, UNL_ARMED} unlock_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadStrobe;
    logic run;
    logic autoReload;
  } dpStrobe_t;
endpackage

// File: rtl/core_wdog_dpath.sv
module core_wdog_dpath
  import core_wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [PRE_W-1:0] prescale,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] cntReg;
  logic [PRE_W-1:0] psCnt;
  logic             tick;
  logic             atZero;

  assign tick   = strobe.run && (psCnt >= prescale);
  assign atZero = (cntReg == '0);
  assign expire = tick && atZero && !strobe.loadStrobe;
  assign count  = cntReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntReg <= '0;
      psCnt  <= '0;
    end else if (strobe.loadStrobe) begin
      cntReg <= loadVal;
      psCnt  <= '0;
    end else if (strobe.run) begin
      if (tick) begin
        psCnt <= '0;
        if (atZero) begin
          if (strobe.autoReload) cntReg <= loadVal;
        end else begin
          cntReg <= cntReg - 1'b1;
        end
      end else begin
        psCnt <= psCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/core_wdog_ctrl.sv
module core_wdog_ctrl
  import core_wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              expire,
  output dpStrobe_t         strobe,
  output logic [CNT_W-1:0]  loadVal,
  output logic [PRE_W-1:0]  prescale,
  output logic              wdMode,
  output logic              irq,
  output logic              rstReq
);
  logic [CNT_W-1:0] loadReg;
  logic             enReg, arReg, ieReg, wdReg, iFlag, rFlag;
  logic [PRE_W-1:0] preReg;
  unlock_e          unlockSt;

  logic wrAcc, loadWr, ctrlWr, iFlagWr, rFlagWr, unlkWr, unlockHit;

  assign wrAcc   = busSel && busWrite;
  assign loadWr  = wrAcc && (busAddr == REG_LOAD);
  assign ctrlWr  = wrAcc && (busAddr == REG_CTRL);
  assign iFlagWr = wrAcc && (busAddr == REG_IFLAG);
  assign rFlagWr = wrAcc && (busAddr == REG_RFLAG);
  assign unlkWr  = wrAcc && (busAddr == REG_UNLK);
  assign unlockHit = unlkWr && (busWdata == KEY_SECOND) && (unlockSt == UNL_ARMED);

  assign strobe.loadStrobe = loadWr;
  assign strobe.run        = enReg;
  assign strobe.autoReload = arReg;
  assign loadVal  = loadWr ? busWdata[CNT_W-1:0] : loadReg;
  assign prescale = preReg;
  assign wdMode   = wdReg;
  assign irq      = iFlag && ieReg && !wdReg;
  assign rstReq   = rFlag;

  always_ff @(posedge clk) begin
    if (!rstN) loadReg <= '0;
    else if (loadWr) loadReg <= busWdata[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg  <= 1'b0;
      arReg  <= 1'b0;
      ieReg  <= 1'b0;
      preReg <= '0;
    end else if (ctrlWr) begin
      enReg  <= busWdata[BIT_EN];
      arReg  <= busWdata[BIT_AR];
      ieReg  <= busWdata[BIT_IE];
      preReg <= busWdata[PRE_LSB +: PRE_W];
    end else if (expire && !arReg) begin
      enReg  <= 1'b0;
    end
  end

  // mode: one write to enter, keyed pair to leave
  always_ff @(posedge clk) begin
    if (!rstN) wdReg <= 1'b0;
    else if (ctrlWr && busWdata[BIT_WD]) wdReg <= 1'b1;
    else if (unlockHit) wdReg <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) unlockSt <= UNL_IDLE;
    else if (busSel) begin
      if (unlkWr && (busWdata == KEY_FIRST)) unlockSt <= UNL_ARMED;
      else unlockSt <= UNL_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) iFlag <= 1'b0;
    else if (expire && !wdReg) iFlag <= 1'b1;
    else if (iFlagWr && busWdata[0]) iFlag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rFlag <= 1'b0;
    else if (expire && wdReg) rFlag <= 1'b1;
    else if (rFlagWr && busWdata[0]) rFlag <= 1'b0;
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      REG_LOAD:  busRdata[CNT_W-1:0] = loadReg;
      REG_COUNT: busRdata[CNT_W-1:0] = count;
      REG_CTRL: begin
        busRdata[BIT_EN] = enReg;
        busRdata[BIT_AR] = arReg;
        busRdata[BIT_IE] = ieReg;
        busRdata[BIT_WD] = wdReg;
        busRdata[PRE_LSB +: PRE_W] = preReg;
      end
      REG_IFLAG: busRdata[0] = iFlag;
      REG_RFLAG: busRdata[0] = rFlag;
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: rtl/core_wdog_timer.sv
module core_wdog_timer
  import core_wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq,
  output logic              rstReq
);
  dpStrobe_t        dpStrobe;
  logic [CNT_W-1:0] loadVal;
  logic [PRE_W-1:0] prescale;
  logic [CNT_W-1:0] count;
  logic             expire;
  logic             wdMode;

  core_wdog_ctrl #(.CNT_W(CNT_W), .PRE_W(PRE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .count(count), .expire(expire), .strobe(dpStrobe), .loadVal(loadVal),
    .prescale(prescale), .wdMode(wdMode), .irq(irq), .rstReq(rstReq)
  );

  core_wdog_dpath #(.CNT_W(CNT_W), .PRE_W(PRE_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(dpStrobe), .loadVal(loadVal),
    .prescale(prescale), .count(count), .expire(expire)
  );
endmodule

// File: rtl/core_wdog_checker.sv
module core_wdog_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             busSel,
  input logic             busWrite,
  input logic [2:0]       busAddr,
  input logic [31:0]      busWdata,
  input logic             irq,
  input logic             rstReq,
  input logic             wdMode,
  input logic             enable,
  input logic [CNT_W-1:0] count
);
  logic loadWr, rClear, unlkAcc;
  assign loadWr  = busSel && busWrite && (busAddr == 3'd0);
  assign rClear  = busSel && busWrite && (busAddr == 3'd4) && busWdata[0];
  assign unlkAcc = busSel && busWrite && (busAddr == 3'd5);

  p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rstN)
    wdMode |-> !irq);

  p_rst_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rstReq && !rClear) |=> rstReq);

  p_mode_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wdMode && !unlkAcc) |=> wdMode);

  p_freeze_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !loadWr) |=> $stable(count));

  p_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    loadWr |=> (count == $past(busWdata[CNT_W-1:0])));
endmodule

bind core_wdog_timer core_wdog_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .irq(irq), .rstReq(rstReq),
  .wdMode(wdMode), .enable(dpStrobe.run), .count(count)
);

// File: tb/core_wdog_timer_tb.sv
`timescale 1ns/100ps
module core_wdog_timer_tb_top;
  localparam int CW = 16;
  localparam longint MASK = (64'd1 << CW) - 1;
  localparam logic [31:0] K1 = 32'h1234_5678;
  localparam logic [31:0] K2 = 32'h8765_4321;
  localparam logic [31:0] EN = 32'h1, AR = 32'h2, IE = 32'h4, WD = 32'h8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [2:0] busAddr = 3'd1;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic irq, rstReq;

  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  core_wdog_timer #(.CNT_W(CW), .PRE_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irq(irq), .rstReq(rstReq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model state
  longint mLoad, mCnt, mPs, mPre;
  bit mEn, mAr, mIe, mWd, mInt, mRst, mArm;
  bit wr, ex, oldWd, oldAr;
  int a;
  logic [31:0] d;

  always @(posedge clk) begin
    if (!rstN) begin
      mLoad = 0; mCnt = 0; mPs = 0; mPre = 0;
      mEn = 0; mAr = 0; mIe = 0; mWd = 0; mInt = 0; mRst = 0; mArm = 0;
    end else begin
      wr = busSel && busWrite; a = busAddr; d = busWdata;
      ex = 0; oldWd = mWd; oldAr = mAr;
      if (wr && a == 0) begin
        mLoad = d & MASK; mCnt = mLoad; mPs = 0;
      end else if (mEn) begin
        if (mPs >= mPre) begin
          mPs = 0;
          if (mCnt == 0) begin ex = 1; if (mAr) mCnt = mLoad; end
          else mCnt = mCnt - 1;
        end else mPs = mPs + 1;
      end
      if (wr && a == 2) begin
        mEn = d[0]; mAr = d[1]; mIe = d[2]; mPre = d[15:8];
        if (d[3]) mWd = 1;
      end else if (ex && !oldAr) mEn = 0;
      if (wr && a == 3 && d[0]) mInt = 0;
      if (ex && !oldWd) mInt = 1;
      if (wr && a == 4 && d[0]) mRst = 0;
      if (ex && oldWd) mRst = 1;
      if (busSel) begin
        if (wr && a == 5 && d == K1) mArm = 1;
        else begin
          if (mArm && wr && a == 5 && d == K2) mWd = 0;
          mArm = 0;
        end
      end
    end
    #2;
    if (rstN) begin
      check("R11 model irq", {31'b0, irq}, {31'b0, mInt && mIe && !mWd});
      check("R10 model rstReq", {31'b0, rstReq}, {31'b0, mRst});
      if (!busSel && busAddr == 3'd1)
        check("R2 model counter", busRdata, 32'(mCnt));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<=60000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wr_reg(input logic [2:0] ad, input logic [31:0] v);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = ad; busWdata = v;
    @(negedge clk);
    busSel = 0; busWrite = 0; busAddr = 3'd1; busWdata = '0;
  endtask

  task automatic rd_access(input logic [2:0] ad);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = ad;
    @(negedge clk);
    busSel = 0; busAddr = 3'd1;
  endtask

  task automatic peek(input logic [2:0] ad, output logic [31:0] v);
    busAddr = ad;
    #0.2;
    v = busRdata;
    busAddr = 3'd1;
  endtask

  initial begin
    logic [31:0] v, v2;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1;
    #0.5;
    // R1 reset state
    peek(3'd2, v); check("R1 ctrl after reset", v, 0);
    peek(3'd0, v); check("R1 load after reset", v, 0);
    peek(3'd1, v); check("R1 counter after reset", v, 0);
    peek(3'd3, v); check("R1 iflag after reset", v, 0);
    peek(3'd4, v); check("R1 rflag after reset", v, 0);
    check("R1 irq after reset", {31'b0, irq}, 0);
    check("R1 rstReq after reset", {31'b0, rstReq}, 0);

    // R2 period (3+1)*(1+1)
    wr_reg(3'd0, 32'hABCD_0003);
    peek(3'd0, v); check("R5 load keeps low bits", v, 3);
    wr_reg(3'd2, EN | AR | IE | (32'd1 << 8));
    n = 0;
    while (!irq && n < 100) begin @(posedge clk); #1; n++; end
    check("R2 period cycles", n, 8);
    peek(3'd1, v); check("R3 reload after expiry", v, 3);
    repeat (8) @(posedge clk);
    #1; peek(3'd1, v); check("R3 second reload one period later", v, 3);

    // R9 write-one-to-clear
    wr_reg(3'd2, 0);
    wr_reg(3'd3, 0);
    peek(3'd3, v); check("R9 write 0 keeps iflag", v, 1);
    wr_reg(3'd3, 1);
    peek(3'd3, v); check("R9 write 1 clears iflag", v, 0);

    // R4 one-shot, R11 interrupt enable gating
    wr_reg(3'd0, 2);
    wr_reg(3'd2, EN);
    repeat (8) @(posedge clk);
    #1;
    peek(3'd2, v); check("R4 enable cleared after one-shot", v, 0);
    peek(3'd1, v); check("R4 counter held at 0", v, 0);
    peek(3'd3, v); check("R11 iflag set", v, 1);
    check("R11 irq low with enable clear", {31'b0, irq}, 0);
    wr_reg(3'd2, IE);
    check("R11 irq high with enable set", {31'b0, irq}, 1);

    // R5 load while counting
    wr_reg(3'd2, IE | EN | AR | (32'd5 << 8));
    repeat (10) @(posedge clk);
    wr_reg(3'd0, 100);
    peek(3'd1, v); check("R5 load while counting", v, 100);

    // R6 freeze
    wr_reg(3'd2, IE | AR | (32'd5 << 8));
    peek(3'd1, v);
    repeat (10) @(posedge clk);
    #1; peek(3'd1, v2); check("R6 frozen counter", v2, v);

    // R7 mode entry, R11 masking in watchdog mode
    check("R11 irq before mode entry", {31'b0, irq}, 1);
    wr_reg(3'd2, WD | IE);
    peek(3'd2, v); check("R7 mode bit set", v & WD, WD);
    check("R11 irq masked in watchdog mode", {31'b0, irq}, 0);
    wr_reg(3'd2, IE);
    peek(3'd2, v); check("R7 clear attempt ignored", v & WD, WD);
    wr_reg(3'd3, 1);

    // R10 watchdog expiry
    wr_reg(3'd0, 5);
    wr_reg(3'd2, WD | EN | AR);
    repeat (20) @(posedge clk);
    #1;
    check("R10 rstReq high", {31'b0, rstReq}, 1);
    peek(3'd4, v); check("R10 rflag set", v, 1);
    peek(3'd3, v); check("R10 iflag stays clear", v, 0);
    wr_reg(3'd2, WD);
    wr_reg(3'd4, 0);
    check("R10 rstReq held after write 0", {31'b0, rstReq}, 1);
    repeat (5) @(posedge clk);
    #1; check("R10 rstReq held while idle", {31'b0, rstReq}, 1);
    wr_reg(3'd4, 1);
    check("R10 rstReq drops after clear", {31'b0, rstReq}, 0);

    // R8 unlock sequence
    wr_reg(3'd5, K2);
    peek(3'd2, v); check("R8 second key alone", v & WD, WD);
    wr_reg(3'd5, K1); rd_access(3'd0); wr_reg(3'd5, K2);
    peek(3'd2, v); check("R8 access between keys", v & WD, WD);
    wr_reg(3'd5, K1); wr_reg(3'd5, 32'hDEAD_BEEF); wr_reg(3'd5, K2);
    peek(3'd2, v); check("R8 wrong key between", v & WD, WD);
    wr_reg(3'd5, K2); wr_reg(3'd5, K1);
    peek(3'd2, v); check("R8 reversed order", v & WD, WD);
    wr_reg(3'd5, K1); wr_reg(3'd5, K2);
    peek(3'd2, v); check("R8 exit after key pair", v & WD, 0);

    repeat (5) @(posedge clk);
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule